// File: doc/BRIEF.md
# Ping-Pong Receive DMA Engine

This block carries received serial bytes from a receive FIFO into memory through two alternating buffers, called A and B. Software arms a buffer by pulsing that buffer's load strobe while it presents a 13-bit first address and a 13-bit last address on shared load buses. The engine writes one byte per accepted transfer at the next address of the buffer in service. After it writes the last address, it drops that buffer's active flag and turns to the other buffer. Software can therefore re-arm one buffer while the other one fills, and no bytes are lost.

The FIFO side and the memory side are both valid/ready streams, and the engine joins them without storage. A memory write is offered only while the buffer in service is active and the FIFO has a byte. The FIFO is popped in exactly the cycle in which memory accepts the write. When memory back-pressure holds `mem_ready` low, the offered address and data stay where they are and nothing is popped. When no buffer is active, `fifo_ready` stays low and the FIFO fills. If the FIFO reports full in that state, an overrun is noted against the buffer that is next in line. That buffer's overrun flag rises only when it has been armed and moves its first byte. A parity error flag records any byte with a parity error that buffer A takes.

Top module: `rxdma_pingpong`

## Requirements
- R1: After `rst_n` low, or for one cycle of `dma_reset`, `act_a`, `act_b`, `ovr_a`, `ovr_b` and `perr_a` read 0, and the next buffer to be served is A.
- R2: A load strobe for an inactive buffer captures `ld_start` and `ld_end` and sets that buffer's active flag on the next clock edge. A load strobe for a buffer whose active flag is set changes nothing.
- R3: A buffer writes addresses from its start to its end inclusive, advancing by one per accepted byte. Its active flag clears on the edge that accepts the byte at its end address.
- R4: Buffers are served in strict turn A, B, A, B. Once one buffer completes, the other is next.
- R5: When the next buffer is inactive and the other one is active, service moves to the active one, which costs one idle cycle.
- R6: `mem_valid` is high exactly when the buffer in service is active and `fifo_valid` is high. `mem_data` equals `fifo_data`. `fifo_ready` is high only when the buffer in service is active and `mem_ready` is high. While `mem_valid` is high and `mem_ready` is low, `mem_addr` holds.
- R7: `fifo_full` while neither buffer is active records a pending overrun against the next buffer. That buffer's overrun flag goes to 1 on the edge that accepts its first byte afterwards. The other buffer's bytes leave the pending overrun in place.
- R8: An overrun flag clears when its buffer is loaded, and on `dma_reset`.
- R9: `perr_a` goes to 1 on the edge that accepts a byte into buffer A with `fifo_perr` high. Such bytes taken by buffer B leave it unchanged. It clears when A is loaded, and on `dma_reset`.
- R10: With no buffer active, `fifo_ready` and `mem_valid` stay 0 whatever `fifo_valid` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_reset | input | 1 | Synchronous receive DMA reset |
| load_a | input | 1 | Arm buffer A strobe |
| load_b | input | 1 | Arm buffer B strobe |
| ld_start | input | 13 | First byte address for the buffer being armed |
| ld_end | input | 13 | Last byte address for the buffer being armed |
| fifo_valid | input | 1 | FIFO holds a byte |
| fifo_ready | output | 1 | Pop the FIFO this cycle |
| fifo_data | input | 8 | FIFO head byte |
| fifo_perr | input | 1 | Head byte carries a parity error |
| fifo_full | input | 1 | FIFO is full |
| mem_valid | output | 1 | Memory byte write offered |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 13 | Write byte address |
| mem_data | output | 8 | Write byte |
| act_a | output | 1 | Buffer A active |
| act_b | output | 1 | Buffer B active |
| ovr_a | output | 1 | Overrun charged to buffer A |
| ovr_b | output | 1 | Overrun charged to buffer B |
| perr_a | output | 1 | Buffer A took a byte with a parity error |

## Verification
The hardest case to reach is an overrun charged to buffer B when software arms A first. Two conditions must hold together: B must be next in line while both buffers are idle, and the pending overrun must survive a whole A fill. The stimulus first lets A complete, which makes B next in line. It then pulses `fifo_full` with nothing armed and arms only A, so service skips to A. The bench checks that A's drain leaves both flags clear, and that B's flag rises on its first byte once B is armed.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic {
    BUF_A = 1'b0,
    BUF_B = 1'b1
  } buf_sel_e;

  localparam int NUM_BUF = 2;

  function automatic buf_sel_e other_buf(input buf_sel_e b);
    return (b == BUF_A) ? BUF_B : BUF_A;
  endfunction
endpackage

// File: rtl/rxdma_buf.sv
module rxdma_buf #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_start,
  input  logic [ADDR_W-1:0] ld_end,
  input  logic              take,
  input  logic              ovr_set,
  output logic              active,
  output logic [ADDR_W-1:0] addr,
  output logic              last,
  output logic              ovr_flag
);
  logic [ADDR_W-1:0] end_q;

  assign last = (addr == end_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      addr     <= '0;
      end_q    <= '0;
      ovr_flag <= 1'b0;
    end else if (clr) begin
      active   <= 1'b0;
      ovr_flag <= 1'b0;
    end else if (load && !active) begin
      addr     <= ld_start;
      end_q    <= ld_end;
      active   <= 1'b1;
      ovr_flag <= 1'b0;
    end else begin
      if (take) begin
        if (last) active <= 1'b0;
        else      addr   <= addr + 1'b1;
      end
      if (ovr_set) ovr_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/rxdma_seq.sv
module rxdma_seq
  import rxdma_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [1:0]   act,
  input  logic         fifo_full,
  input  logic         xfer,
  input  logic         last_cur,
  output buf_sel_e     cur,
  output logic         pend,
  output buf_sel_e     pend_tgt
);
  buf_sel_e nxt;
  assign nxt = other_buf(cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= BUF_A;
    end else if (clr) begin
      cur <= BUF_A;
    end else if (xfer && last_cur) begin
      cur <= nxt;
    end else if (!act[cur] && act[nxt]) begin
      cur <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      pend_tgt <= BUF_A;
    end else if (clr) begin
      pend     <= 1'b0;
      pend_tgt <= BUF_A;
    end else if (!pend && act == 2'b00 && fifo_full) begin
      pend     <= 1'b1;
      pend_tgt <= cur;
    end else if (pend && xfer && cur == pend_tgt) begin
      pend     <= 1'b0;
    end
  end
endmodule

// File: rtl/rxdma_port.sv
module rxdma_port #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              cur_active,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              fifo_valid,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              mem_ready,
  output logic              fifo_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              xfer
);
  always_comb begin
    mem_valid  = cur_active && fifo_valid;
    fifo_ready = cur_active && mem_ready;
    mem_addr   = cur_addr;
    mem_data   = fifo_data;
    xfer       = mem_valid && mem_ready;
  end
endmodule

// File: rtl/rxdma_pingpong.sv
module rxdma_pingpong
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_reset,
  input  logic              load_a,
  input  logic              load_b,
  input  logic [ADDR_W-1:0] ld_start,
  input  logic [ADDR_W-1:0] ld_end,
  input  logic              fifo_valid,
  output logic              fifo_ready,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_perr,
  input  logic              fifo_full,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              act_a,
  output logic              act_b,
  output logic              ovr_a,
  output logic              ovr_b,
  output logic              perr_a
);
  logic [NUM_BUF-1:0] load_v, take_v, ovrset_v, act_v, last_v, ovr_v;
  logic [ADDR_W-1:0]  addr_v [NUM_BUF];
  buf_sel_e           cur, pend_tgt;
  logic               pend, xfer, perr_q;

  assign load_v = {load_b, load_a};

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    assign take_v[i]   = xfer && (cur == buf_sel_e'(i));
    assign ovrset_v[i] = take_v[i] && pend && (pend_tgt == buf_sel_e'(i));
    rxdma_buf #(.ADDR_W(ADDR_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (dma_reset),
      .load     (load_v[i]),
      .ld_start (ld_start),
      .ld_end   (ld_end),
      .take     (take_v[i]),
      .ovr_set  (ovrset_v[i]),
      .active   (act_v[i]),
      .addr     (addr_v[i]),
      .last     (last_v[i]),
      .ovr_flag (ovr_v[i])
    );
  end

  rxdma_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (dma_reset),
    .act       (act_v),
    .fifo_full (fifo_full),
    .xfer      (xfer),
    .last_cur  (last_v[cur]),
    .cur       (cur),
    .pend      (pend),
    .pend_tgt  (pend_tgt)
  );

  rxdma_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .cur_active (act_v[cur]),
    .cur_addr   (addr_v[cur]),
    .fifo_valid (fifo_valid),
    .fifo_data  (fifo_data),
    .mem_ready  (mem_ready),
    .fifo_ready (fifo_ready),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .xfer       (xfer)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    perr_q <= 1'b0;
    else if (dma_reset)            perr_q <= 1'b0;
    else if (load_a && !act_v[0])  perr_q <= 1'b0;
    else if (take_v[0] && fifo_perr) perr_q <= 1'b1;
  end

  assign act_a  = act_v[0];
  assign act_b  = act_v[1];
  assign ovr_a  = ovr_v[0];
  assign ovr_b  = ovr_v[1];
  assign perr_a = perr_q;
endmodule

// File: rtl/rxdma_chk.sv
module rxdma_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dma_reset,
  input logic              load_a,
  input logic              fifo_ready,
  input logic              fifo_perr,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              act_a,
  input logic              act_b,
  input logic              ovr_a,
  input logic              ovr_b,
  input logic              perr_a
);
  // R10
  pop_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> (act_a || act_b));

  // R1
  dma_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_reset |=> (!act_a && !act_b && !ovr_a && !ovr_b && !perr_a));

  // R9
  perr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr_a) |-> $past(mem_valid && mem_ready && fifo_perr));

  // R7
  ovr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovr_a) || $rose(ovr_b)) |-> $past(mem_valid && mem_ready));

  // R2
  load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_a && act_a && !dma_reset && !(mem_valid && mem_ready)) |=> act_a);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !dma_reset) |=> $stable(mem_addr));
endmodule

bind rxdma_pingpong rxdma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dma_reset  (dma_reset),
  .load_a     (load_a),
  .fifo_ready (fifo_ready),
  .fifo_perr  (fifo_perr),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .act_a      (act_a),
  .act_b      (act_b),
  .ovr_a      (ovr_a),
  .ovr_b      (ovr_b),
  .perr_a     (perr_a)
);

// File: tb/tb_rxdma_pingpong.sv
module tb_rxdma_pingpong;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_reset = 1'b0, load_a = 1'b0, load_b = 1'b0;
  logic [AW-1:0] ld_start = '0, ld_end = '0;
  logic fifo_valid = 1'b0, fifo_perr = 1'b0, fifo_full = 1'b0, mem_ready = 1'b0;
  logic [7:0] fifo_data = '0;
  logic fifo_ready, mem_valid;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;
  logic act_a, act_b, ovr_a, ovr_b, perr_a;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdma_pingpong dut (
    .clk(clk), .rst_n(rst_n), .dma_reset(dma_reset),
    .load_a(load_a), .load_b(load_b), .ld_start(ld_start), .ld_end(ld_end),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_data(fifo_data),
    .fifo_perr(fifo_perr), .fifo_full(fifo_full),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .act_a(act_a), .act_b(act_b), .ovr_a(ovr_a), .ovr_b(ovr_b), .perr_a(perr_a)
  );

  // {A start, A end, B start, B end}
  localparam logic [4*AW-1:0] VEC [3] = '{
    {13'h0100, 13'h0102, 13'h0200, 13'h0201},
    {13'h1FFE, 13'h1FFF, 13'h0000, 13'h0000},
    {13'h0010, 13'h0013, 13'h0020, 13'h0022}
  };

  task automatic check(input bit ok, input string req, input int actual, input int expect_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expect_v);
    end
  endtask

  task automatic load(input bit sel_b, input logic [AW-1:0] s, input logic [AW-1:0] e);
    @(negedge clk);
    ld_start = s; ld_end = e;
    if (sel_b) load_b = 1'b1; else load_a = 1'b1;
    @(posedge clk); #1;
    load_a = 1'b0; load_b = 1'b0;
  endtask

  task automatic pulse_dma_reset();
    @(negedge clk); dma_reset = 1'b1;
    @(posedge clk); #1; dma_reset = 1'b0;
  endtask

  task automatic pulse_full();
    @(negedge clk); fifo_full = 1'b1;
    @(posedge clk); #1; fifo_full = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input bit pe, input logic [AW-1:0] exp_addr, input string req);
    int n;
    @(negedge clk);
    fifo_valid = 1'b1; fifo_data = d; fifo_perr = pe; mem_ready = 1'b1;
    #1; n = 0;
    while (!mem_valid && n < 4) begin @(negedge clk); #1; n++; end
    check(mem_valid && mem_addr == exp_addr, req, int'(mem_addr), int'(exp_addr));
    check(mem_data == d && fifo_ready, "R6 data/pop", int'(mem_data), int'(d));
    @(posedge clk); #1;
    fifo_valid = 1'b0; fifo_perr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 / R10: reset state, no pop with nothing armed
    @(negedge clk); fifo_valid = 1'b1; mem_ready = 1'b1; #1;
    check({act_a, act_b, ovr_a, ovr_b, perr_a} == 5'b0, "R1 reset flags", {act_a, act_b, ovr_a, ovr_b, perr_a}, 0);
    check(!fifo_ready && !mem_valid, "R10 idle no pop", {fifo_ready, mem_valid}, 0);
    @(negedge clk); fifo_valid = 1'b0;

    // R2 R3 R4: table walk, A then B
    foreach (VEC[k]) begin
      logic [AW-1:0] sa, ea, sb, eb;
      {sa, ea, sb, eb} = VEC[k];
      load(1'b0, sa, ea);
      load(1'b1, sb, eb);
      check(act_a && act_b, "R2 both armed", {act_a, act_b}, 3);
      for (int a = int'(sa); a <= int'(ea); a++) push(8'(a + k), 1'b0, AW'(a), "R3 A address");
      check(!act_a && act_b, "R3 A completes", {act_a, act_b}, 1);
      for (int b = int'(sb); b <= int'(eb); b++) push(8'(b ^ 8'h5A), 1'b0, AW'(b), "R4 B follows A");
      check(!act_a && !act_b, "R3 B completes", {act_a, act_b}, 0);
    end

    // R6: back-pressure holds the offer
    load(1'b0, 13'h0040, 13'h0041);
    @(negedge clk); fifo_valid = 1'b1; fifo_data = 8'h77; mem_ready = 1'b0; #1;
    check(mem_valid && !fifo_ready && mem_addr == 13'h0040, "R6 stall offer", int'(mem_addr), 'h40);
    @(negedge clk); #1;
    check(mem_valid && mem_addr == 13'h0040 && act_a, "R6 stall hold", int'(mem_addr), 'h40);
    fifo_valid = 1'b0;
    push(8'h11, 1'b0, 13'h0040, "R6 resume");
    push(8'h12, 1'b0, 13'h0041, "R6 resume");

    // R2: load of an active buffer is ignored
    load(1'b0, 13'h0300, 13'h0301);
    load(1'b0, 13'h0400, 13'h04FF);
    push(8'h21, 1'b0, 13'h0300, "R2 reload ignored");
    push(8'h22, 1'b0, 13'h0301, "R2 reload ignored");
    check(!act_a, "R2 end kept", act_a, 0);

    // R1 / R5: dma reset makes A next; arming only B skips to B
    pulse_dma_reset();
    load(1'b1, 13'h0600, 13'h0600);
    push(8'h31, 1'b0, 13'h0600, "R5 skip to B");
    check(!act_b, "R5 B completes", act_b, 0);

    // R7: overrun charged to A (next in line)
    pulse_full();
    check(!ovr_a && !ovr_b, "R7 not yet flagged", {ovr_a, ovr_b}, 0);
    load(1'b0, 13'h0800, 13'h0801);
    push(8'h41, 1'b0, 13'h0800, "R7 A drains");
    check(ovr_a && !ovr_b, "R7 ovr to A", {ovr_a, ovr_b}, 2);
    push(8'h42, 1'b0, 13'h0801, "R7 A drains");

    // R7 / R8: B next in line, A armed first
    pulse_full();
    load(1'b0, 13'h0900, 13'h0900);
    check(!ovr_a, "R8 load clears A overrun", ovr_a, 0);
    push(8'h51, 1'b0, 13'h0900, "R7 A skip");
    check(!ovr_a && !ovr_b, "R7 A drain leaves pending", {ovr_a, ovr_b}, 0);
    load(1'b1, 13'h0A00, 13'h0A01);
    push(8'h52, 1'b0, 13'h0A00, "R7 B drains");
    check(ovr_b && !ovr_a, "R7 ovr to B", {ovr_a, ovr_b}, 1);
    push(8'h53, 1'b0, 13'h0A01, "R7 B drains");
    load(1'b1, 13'h0B00, 13'h0B00);
    check(!ovr_b, "R8 load clears B overrun", ovr_b, 0);
    push(8'h54, 1'b0, 13'h0B00, "R5 skip to B");

    // R9: parity flag on A only
    load(1'b0, 13'h0C00, 13'h0C00);
    push(8'h61, 1'b1, 13'h0C00, "R9 A perr byte");
    check(perr_a, "R9 set by A", perr_a, 1);
    load(1'b1, 13'h0C10, 13'h0C10);
    push(8'h62, 1'b1, 13'h0C10, "R9 B perr byte");
    check(perr_a, "R9 B leaves flag", perr_a, 1);
    load(1'b0, 13'h0C20, 13'h0C20);
    check(!perr_a, "R9 load A clears", perr_a, 0);
    push(8'h63, 1'b1, 13'h0C20, "R9 A perr byte");
    check(perr_a, "R9 set again", perr_a, 1);

    // R1 / R8: dma reset clears flags and activity
    pulse_full();
    load(1'b1, 13'h0D00, 13'h0D01);
    push(8'h71, 1'b0, 13'h0D00, "R7 B drains");
    check(ovr_b && act_b, "R7 ovr to B again", {ovr_b, act_b}, 3);
    pulse_dma_reset();
    check({act_a, act_b, ovr_a, ovr_b, perr_a} == 5'b0, "R8 dma reset clears", {act_a, act_b, ovr_a, ovr_b, perr_a}, 0);
    @(negedge clk); fifo_valid = 1'b1; #1;
    check(!mem_valid && !fifo_ready, "R10 after dma reset", {mem_valid, fifo_ready}, 0);
    fifo_valid = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule